// File: doc/BRIEF.md
# Microprogram Sequencer with Single-Step Debug Word

This block is the program counter and control unit for a DSP that runs a fixed-length microprogram once per audio sample. A sample tick starts a pass. From then on the block issues one instruction address per clock. After the last address it wraps to zero and waits for the next tick. Instruction memory and the arithmetic unit sit outside the block. The sequencer receives the decoded opcode and operand values for the address it is currently issuing, together with a saturation pulse and the condition code that the arithmetic unit reports.

The sequencer runs a conditional skip instruction. The condition register value is ANDed with a test pattern. When the result is nonzero, the following instructions, up to a given count, go out as no-ops: the address still advances, but the valid flag stays low.

A 32-bit debug word gives the following:
- a halt and single-step mode, which can set the program counter and step one instruction at a time;
- a sticky record of the first saturating instruction and its address;
- a live view of the condition code;
- a one-cycle strobe that asks an external delay-line base counter to clear.

Top module: `mseq_top`

## Requirements
- R1: While reset is asserted and after it is released, pc_o is 0, instr_valid_o is 0, zero_dly_o is 0, and debug word bits 31:14 and 8:0 read 0.
- R2: With single-step mode off and no pass running, tick_i starts a pass in the next cycle at the current pc_o. One address is issued per cycle, pc_o increments by one each cycle, and instr_valid_o is high except in skipped slots.
- R3: After address PROG_LEN-1 is issued, pc_o returns to 0 and no further instruction is issued until the next tick. A tick that arrives while a pass is running has no effect on the pass.
- R4: An issued instruction with opcode 4'hF (skip) whose operand A ANDed with operand Y is nonzero makes the next X issued slots invalid (instr_valid_o low) while pc_o keeps advancing. X above the counter range saturates, and skipping stops at the end of the pass. A zero AND result skips nothing.
- R5: The first issued instruction (instr_valid_o high) that coincides with sat_i sets debug bit 25 and stores its address in bits 24:16. Later saturations do not change either field.
- R6: The saturation flag and address are cleared only by a debug write with bit 25 = 0. A write with bit 25 = 1 leaves them unchanged. In a cycle with a debug write, saturation is not captured.
- R7: A debug write with bit 15 = 1 and bit 14 = 0 enters single-step mode, stops the pass, and loads pc_o from bits 8:0. In this mode, ticks issue nothing and pc_o holds.
- R8: A debug write with bits 15 and 14 both set issues the instruction at pc_o for exactly one cycle in the next cycle. pc_o then advances by one, wrapping from PROG_LEN-1 to 0.
- R9: Reading the debug word gives pc_o in bits 8:0, cc_i in bits 13:9, the mode in bit 15, the saturation fields in bits 25 and 24:16, and 0 elsewhere.
- R10: A debug write with bit 31 = 1 drives zero_dly_o high for exactly the next cycle.
- R11: A debug write with bit 15 = 0 leaves single-step mode with pc_o unchanged. The next tick then runs a pass from that address to the end of the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample tick, starts a pass |
| opcode_i | input | 4 | Decoded opcode of the instruction at pc_o |
| opa_i | input | 32 | Operand A value (condition register for skip) |
| opx_i | input | 32 | Operand X value (skip count) |
| opy_i | input | 32 | Operand Y value (test pattern) |
| sat_i | input | 1 | Saturation pulse for the instruction at pc_o |
| cc_i | input | 5 | Current condition code |
| dbg_we_i | input | 1 | Debug word write strobe |
| dbg_wdata_i | input | 32 | Debug word write data |
| pc_o | output | 9 | Instruction address |
| instr_valid_o | output | 1 | The instruction at pc_o executes this cycle |
| dbg_rdata_o | output | 32 | Debug word read value |
| zero_dly_o | output | 1 | One-cycle request to clear the delay base counter |

## Verification
The assertions assume the following about the inputs:
- The opcode and operand inputs belong to the address on pc_o in the same cycle.
- sat_i refers to that same slot.

The bench meets this by deriving the opcode, operands and saturation pulse combinationally from pc_o, using a small program model held in the bench. The assertions also assume that debug writes last one cycle and that PROG_LEN fits the 9-bit address field. Every write in the bench is a single-cycle strobe driven between clock edges, and the bench uses a 16-instruction program.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned CC_W   = 5;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned DBG_W  = 32;

  // debug word layout
  localparam int unsigned B_PC_LSB   = 0;
  localparam int unsigned B_CC_LSB   = 9;
  localparam int unsigned B_STEP     = 14;
  localparam int unsigned B_SSMODE   = 15;
  localparam int unsigned B_SATA_LSB = 16;
  localparam int unsigned B_SATF     = 25;
  localparam int unsigned B_ZERO     = 31;

  localparam logic [OPC_W-1:0] OPC_SKIP = 4'hF;

  typedef struct packed {
    logic              load;     // enter/stay halted, load pc
    logic              step;     // issue one instruction
    logic              leave;    // leave single-step mode
    logic [ADDR_W-1:0] addr;
  } dbg_ctl_t;
endpackage

// File: rtl/mseq_skip.sv
module mseq_skip #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              is_skip_i,
  input  logic [DATA_W-1:0] cond_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] test_i,
  input  logic              advance_i,
  input  logic              flush_i,
  output logic              busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_ld;
  logic             hit;

  assign hit    = issue_i && is_skip_i && (|(cond_i & test_i));
  assign cnt_ld = (|count_i[DATA_W-1:CNT_W]) ? '1 : count_i[CNT_W-1:0];
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (flush_i)           cnt_q <= '0;
    else if (hit)               cnt_q <= cnt_ld;
    else if (busy_o && advance_i) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/mseq_pc.sv
module mseq_pc
  import mseq_pkg::*;
#(
  parameter int unsigned PROG_LEN = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ss_mode_i,
  input  dbg_ctl_t          ctl_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              active_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PROG_LEN - 1);

  logic [ADDR_W-1:0] pc_q;
  logic              run_q;
  logic              step_q;

  assign active_o = ss_mode_i ? step_q : run_q;
  assign last_o   = (pc_q == LAST);
  assign pc_o     = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      run_q  <= 1'b0;
      step_q <= 1'b0;
    end else if (ctl_i.load) begin
      pc_q   <= ctl_i.addr;
      run_q  <= 1'b0;
      step_q <= 1'b0;
    end else if (ctl_i.step) begin
      run_q  <= 1'b0;
      step_q <= 1'b1;
    end else begin
      if (active_o) begin
        pc_q   <= last_o ? '0 : pc_q + ADDR_W'(1);
        step_q <= 1'b0;
        if (last_o) run_q <= 1'b0;
      end else if (tick_i && !ss_mode_i) begin
        run_q <= 1'b1;
      end
      if (ctl_i.leave) step_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mseq_dbg.sv
module mseq_dbg
  import mseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DBG_W-1:0]  wdata_i,
  input  logic              sat_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic              ss_mode_o,
  output dbg_ctl_t          ctl_o,
  output logic [DBG_W-1:0]  rdata_o,
  output logic              zero_o
);
  logic              ss_q;
  logic              satf_q;
  logic [ADDR_W-1:0] sata_q;
  logic              zero_q;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata_i[30:26], wdata_i[24:16], wdata_i[13:9]};

  always_comb begin
    ctl_o.load  = we_i && wdata_i[B_SSMODE] && !wdata_i[B_STEP];
    ctl_o.step  = we_i && wdata_i[B_SSMODE] && wdata_i[B_STEP];
    ctl_o.leave = we_i && !wdata_i[B_SSMODE];
    ctl_o.addr  = wdata_i[B_PC_LSB +: ADDR_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q   <= 1'b0;
      satf_q <= 1'b0;
      sata_q <= '0;
      zero_q <= 1'b0;
    end else begin
      zero_q <= we_i && wdata_i[B_ZERO];
      if (we_i) begin
        ss_q <= wdata_i[B_SSMODE];
        if (!wdata_i[B_SATF]) begin
          satf_q <= 1'b0;
          sata_q <= '0;
        end
      end else if (sat_i && valid_i && !satf_q) begin
        satf_q <= 1'b1;
        sata_q <= pc_i;
      end
    end
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[B_PC_LSB +: ADDR_W]    = pc_i;
    rdata_o[B_CC_LSB +: CC_W]      = cc_i;
    rdata_o[B_SSMODE]              = ss_q;
    rdata_o[B_SATA_LSB +: ADDR_W]  = sata_q;
    rdata_o[B_SATF]                = satf_q;
  end

  assign ss_mode_o = ss_q;
  assign zero_o    = zero_q;
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int unsigned PROG_LEN = 512,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opx_i,
  input  logic [DATA_W-1:0] opy_i,
  input  logic              sat_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic              dbg_we_i,
  input  logic [DBG_W-1:0]  dbg_wdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              instr_valid_o,
  output logic [DBG_W-1:0]  dbg_rdata_o,
  output logic              zero_dly_o
);
  localparam int unsigned CNT_W = $clog2(PROG_LEN) + 1;

  dbg_ctl_t          ctl;
  logic              ss_mode;
  logic              active;
  logic              last;
  logic              skip_busy;
  logic [ADDR_W-1:0] pc;

  assign instr_valid_o = active && !skip_busy;
  assign pc_o          = pc;

  mseq_pc #(.PROG_LEN(PROG_LEN)) i_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .ss_mode_i (ss_mode),
    .ctl_i     (ctl),
    .pc_o      (pc),
    .active_o  (active),
    .last_o    (last)
  );

  mseq_skip #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_skip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (instr_valid_o),
    .is_skip_i (opcode_i == OPC_SKIP),
    .cond_i    (opa_i),
    .count_i   (opx_i),
    .test_i    (opy_i),
    .advance_i (active),
    .flush_i   ((active && last) || ctl.load),
    .busy_o    (skip_busy)
  );

  mseq_dbg i_dbg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dbg_we_i),
    .wdata_i   (dbg_wdata_i),
    .sat_i     (sat_i),
    .valid_i   (instr_valid_o),
    .pc_i      (pc),
    .cc_i      (cc_i),
    .ss_mode_o (ss_mode),
    .ctl_o     (ctl),
    .rdata_o   (dbg_rdata_o),
    .zero_o    (zero_dly_o)
  );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
  import mseq_pkg::*;
#(
  parameter int unsigned PROG_LEN = 512,
  parameter int unsigned DATA_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opx_i,
  input logic [DATA_W-1:0] opy_i,
  input logic              dbg_we_i,
  input logic [DBG_W-1:0]  dbg_wdata_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              instr_valid_o,
  input logic [DBG_W-1:0]  dbg_rdata_o,
  input logic              zero_dly_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PROG_LEN - 1);

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && pc_o != LAST && !dbg_we_i) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && pc_o == LAST && !dbg_we_i) |=> (pc_o == '0));

  assert_skip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !dbg_we_i && opcode_i == OPC_SKIP && (|(opa_i & opy_i))
     && opx_i != '0 && pc_o != LAST) |=> !instr_valid_o);

  assert_sat_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_rdata_o[B_SATF] && !dbg_we_i) |=>
      (dbg_rdata_o[B_SATF] && $stable(dbg_rdata_o[B_SATA_LSB +: ADDR_W])));

  assert_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_rdata_o[B_SSMODE] && !dbg_we_i) |=> !instr_valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_rdata_o[B_SSMODE] && !dbg_we_i && !$past(dbg_we_i)) |=> $stable(pc_o));

  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_we_i && dbg_wdata_i[B_SSMODE] && dbg_wdata_i[B_STEP]) |=> (pc_o == $past(pc_o)));

  assert_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_we_i && dbg_wdata_i[B_ZERO]) |=> zero_dly_o);

  assert_zero_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_we_i || !dbg_wdata_i[B_ZERO]) |=> !zero_dly_o);
endmodule

bind mseq_top mseq_chk #(.PROG_LEN(PROG_LEN), .DATA_W(DATA_W)) i_mseq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .opcode_i      (opcode_i),
  .opa_i         (opa_i),
  .opx_i         (opx_i),
  .opy_i         (opy_i),
  .dbg_we_i      (dbg_we_i),
  .dbg_wdata_i   (dbg_wdata_i),
  .pc_o          (pc_o),
  .instr_valid_o (instr_valid_o),
  .dbg_rdata_o   (dbg_rdata_o),
  .zero_dly_o    (zero_dly_o)
);

// File: tb/test_mseq_top.sv
module test_mseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN       = 16;
  localparam int SKIP_AT    = 2;
  localparam int NVEC       = 6;
  // {cond, test, count, expected valid slots in one pass}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h01, 8'h01, 8'd3,  8'd13},
    {8'h0C, 8'h04, 8'd1,  8'd15},
    {8'h0A, 8'h05, 8'd5,  8'd16},
    {8'h80, 8'hFF, 8'd0,  8'd16},
    {8'hFF, 8'h10, 8'd20, 8'd3},
    {8'h02, 8'h02, 8'd13, 8'd3}
  };
  localparam logic [4:0] CC_VAL = 5'h15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [3:0]  opcode_i;
  logic [31:0] opa_i, opx_i, opy_i;
  logic        sat_i;
  logic        dbg_we_i = 1'b0;
  logic [31:0] dbg_wdata_i = '0;
  logic [8:0]  pc_o;
  logic        instr_valid_o;
  logic [31:0] dbg_rdata_o;
  logic        zero_dly_o;

  logic        skip_en = 1'b0;
  logic [31:0] s_cond = '0, s_cnt = '0, s_test = '0;
  logic        sat_en = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // program model: skip at SKIP_AT, saturation at addresses 5 and 9
  always_comb begin
    opcode_i = (skip_en && pc_o == 9'(SKIP_AT)) ? 4'hF : 4'h0;
    opa_i    = s_cond;
    opx_i    = s_cnt;
    opy_i    = s_test;
    sat_i    = sat_en && (pc_o == 9'd5 || pc_o == 9'd9);
  end

  mseq_top #(.PROG_LEN(PLEN)) i_mseq_top (
    .clk_i, .rst_ni, .tick_i, .opcode_i, .opa_i, .opx_i, .opy_i, .sat_i,
    .cc_i(CC_VAL), .dbg_we_i, .dbg_wdata_i, .pc_o, .instr_valid_o,
    .dbg_rdata_o, .zero_dly_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dbg_write(input logic [31:0] w);
    @(negedge clk_i); dbg_we_i = 1'b1; dbg_wdata_i = w;
    @(negedge clk_i); dbg_we_i = 1'b0; dbg_wdata_i = '0;
  endtask

  // runs a pass from start_pc; returns valid slot count; checks pc sequence
  task automatic run_pass(input int start_pc, input bit mid_tick, output int nval);
    int ncyc = PLEN - start_pc;
    bit seq_ok = 1'b1;
    nval = 0;
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      if (pc_o != 9'(start_pc + i)) seq_ok = 1'b0;
      if (instr_valid_o) nval++;
      if (mid_tick) tick_i = (i == 5);
      @(negedge clk_i);
    end
    tick_i = 1'b0;
    chk(seq_ok, "R2 pc sequence", 32'(pc_o), 32'(start_pc));
    chk(pc_o == 9'd0 && !instr_valid_o, "R3 wrap and wait", {pc_o, 3'b0, instr_valid_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nv;
    // R1 reset
    #(CLK_PERIOD * 3);
    chk(pc_o == 0 && !instr_valid_o && !zero_dly_o, "R1 reset outputs",
        {pc_o, instr_valid_o, zero_dly_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dbg_rdata_o == {18'b0, CC_VAL, 9'b0}, "R1 R9 reset debug word",
        dbg_rdata_o, {18'b0, CC_VAL, 9'b0});
    chk(!instr_valid_o, "R1 idle after reset", 32'(instr_valid_o), 0);

    // R4 vector table
    skip_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      s_cond = 32'(VEC[v][31:24]);
      s_test = 32'(VEC[v][23:16]);
      s_cnt  = 32'(VEC[v][15:8]);
      run_pass(0, 1'b0, nv);
      chk(nv == int'(VEC[v][7:0]), "R4 skip valid count", 32'(nv), 32'(VEC[v][7:0]));
    end
    // R4 count above counter range saturates, cut at end
    s_cond = 1; s_test = 1; s_cnt = 32'h0001_0000;
    run_pass(0, 1'b0, nv);
    chk(nv == 3, "R4 saturated count", 32'(nv), 3);
    skip_en = 1'b0;

    // R3 tick mid-pass ignored
    run_pass(0, 1'b1, nv);
    chk(nv == PLEN, "R3 mid tick ignored", 32'(nv), 32'(PLEN));
    repeat (3) @(negedge clk_i);
    chk(!instr_valid_o && pc_o == 0, "R3 waits for tick", {pc_o, instr_valid_o}, 0);

    // R5 saturation capture
    sat_en = 1'b1;
    run_pass(0, 1'b0, nv);
    sat_en = 1'b0;
    chk(dbg_rdata_o[25] && dbg_rdata_o[24:16] == 9'd5, "R5 first saturation",
        32'(dbg_rdata_o[25:16]), 32'h205);
    // R6 write with bit 25 set keeps it
    dbg_write(32'h0200_0000);
    chk(dbg_rdata_o[25:16] == 10'h205, "R6 keep on bit25 write",
        32'(dbg_rdata_o[25:16]), 32'h205);
    // R10 strobe
    dbg_write(32'h8200_0000);
    chk(zero_dly_o, "R10 strobe high", 32'(zero_dly_o), 1);
    @(negedge clk_i);
    chk(!zero_dly_o, "R10 strobe one cycle", 32'(zero_dly_o), 0);
    // R6 clear
    dbg_write(32'h0);
    chk(dbg_rdata_o[25:16] == 0, "R6 cleared", 32'(dbg_rdata_o[25:16]), 0);

    // R7 enter single-step with load
    dbg_write(32'h0000_8007);
    chk(pc_o == 7 && !instr_valid_o, "R7 load halt", {pc_o, instr_valid_o}, 32'he);
    chk(dbg_rdata_o == 32'h0000_AA07, "R9 debug layout", dbg_rdata_o, 32'h0000_AA07);
    @(negedge clk_i); tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(pc_o == 7 && !instr_valid_o, "R7 tick ignored in halt", {pc_o, instr_valid_o}, 32'he);
    // R8 step
    @(negedge clk_i); dbg_we_i = 1'b1; dbg_wdata_i = 32'h0000_C000;
    @(negedge clk_i); dbg_we_i = 1'b0; dbg_wdata_i = '0;
    chk(instr_valid_o && pc_o == 7, "R8 step issues", {pc_o, instr_valid_o}, 32'hf);
    @(negedge clk_i);
    chk(!instr_valid_o && pc_o == 8, "R8 step advances", {pc_o, instr_valid_o}, 32'h10);
    // R8 wrap on step
    dbg_write(32'h0000_800F);
    dbg_write(32'h0000_C000);
    @(negedge clk_i);
    chk(pc_o == 0 && !instr_valid_o, "R8 step wrap", {pc_o, instr_valid_o}, 0);
    // R11 leave mode and run from address 8
    dbg_write(32'h0000_8008);
    dbg_write(32'h0);
    chk(pc_o == 8 && !dbg_rdata_o[15], "R11 leave keeps pc", {pc_o, dbg_rdata_o[15]}, 32'h10);
    run_pass(8, 1'b0, nv);
    chk(nv == 8, "R11 partial pass", 32'(nv), 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule